// File: doc/BRIEF.md
# Consecutive-Fault Qualifier with Setup Word

This block turns raw per-sample fault results into confirmed faults. It keeps one run counter for each monitored temperature channel. A channel is reported as faulty only after an unbroken run of positive samples reaches the configured totalize amount. A single negative sample restarts that channel's run.

A positive sample that arrives when the channel's run has already reached the amount is treated as a totalizer overflow. The block then locks into an error state and ignores all further samples. Only a rewrite of the setup word releases the lock.

The same 14-bit setup word also selects the source of the open-wire scan tick. The tick can follow the temperature-scan tick or the cell-scan tick. When the cell scan runs faster than the fixed wire-scan interval, the tick is derived from the cell-scan tick by division.

Top module: `fault_qualifier`

## Requirements
- R1: After reset the setup word reads 14'h0170. That value means: channel 0 (internal) enabled, channels 1..4 disabled, totalizer code 3, wire-scan select 1 and scan code 0. After reset all confirmed-fault outputs, the error flag and the wire tick are 0.
- R2: A write stores all 14 bits of the write data. The stored word is visible on the read port from the next cycle.
- R3: Setup bits [7:5] hold a totalizer code n, and the totalize amount is 2^n. An enabled channel's confirmed output rises in the cycle after its 2^n-th consecutive positive sample. It then stays set until the next setup write.
- R4: A negative sample on an enabled channel clears that channel's run. A confirmation after that needs a full new run.
- R5: Setup bit 8 enables channel 0, and bits 9..12 enable channels 1..4. A disabled channel never confirms, whatever its samples are.
- R6: A positive sample on a channel whose run already equals the amount sets the error flag in the next cycle. While the flag is set, samples change no run counter and no confirmed output.
- R7: A setup write clears every run counter, every confirmed output and the error flag. A sample in the same cycle as a write is discarded.
- R8: With setup bit 4 at 1, the wire tick is the temperature-scan tick delayed by one cycle.
- R9: With bit 4 at 0 and a scan code (bits [3:0]) of 6 or more, the wire tick is the cell-scan tick delayed by one cycle.
- R10: With bit 4 at 0 and a scan code c of 5 or less, the wire tick pulses one cycle after every 2^(5-c)-th cell-scan tick. Counting starts from reset or from the last setup write.
- R11: A sample whose channel index is 5, 6 or 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Setup word write strobe |
| regWrData | input | 14 | Setup word write data |
| regRdData | output | 14 | Stored setup word |
| sampleValid | input | 1 | Sample result strobe |
| sampleFault | input | 1 | Sample result is positive (fault seen) |
| sampleChan | input | 3 | Channel index of the sample |
| cellTick | input | 1 | Cell-scan tick |
| tempTick | input | 1 | Temperature-scan tick |
| wireTick | output | 1 | Open-wire scan tick |
| faultConfirmed | output | 5 | Confirmed fault for each channel |
| totalError | output | 1 | Totalizer overflow error flag |

## Verification
Two functions can fall in the same cycle: a setup write and a sample strobe. The block must let the write win, so the colliding sample is lost and does not count toward the new configuration's run. The bench provokes this in a directed case, with a positive sample at an amount of one that would otherwise confirm at once. Random writes then land on random samples many more times. Each collision is judged against a bench model that drops the sample and clears all run state in that cycle.

// File: rtl/fq_pkg.sv
package fq_pkg;
  localparam int NUM_CH    = 5;
  localparam int CH_W      = 3;
  localparam int TOT_W     = 3;
  localparam int CNT_W     = 1 << TOT_W;
  localparam int SCAN_W    = 4;
  localparam int SETUP_W   = 14;
  localparam int FIXED_EXP = 5;
  localparam int EN_LSB    = 8;
  localparam int TOT_LSB   = 5;
  localparam int WSEL_BIT  = 4;
  localparam logic [SETUP_W-1:0] SETUP_RST = 14'h0170;

  typedef struct packed {
    logic              clrAll;
    logic [NUM_CH-1:0] incMask;
    logic [NUM_CH-1:0] rstMask;
    logic [CNT_W-1:0]  amount;
  } fq_strobe_t;
endpackage

// File: rtl/fq_ctrl.sv
module fq_ctrl
  import fq_pkg::*;
#(
  parameter int NCH  = NUM_CH,
  parameter int CHW  = CH_W,
  parameter int SW   = SETUP_W,
  parameter int FEXP = FIXED_EXP
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           regWrEn,
  input  logic [SW-1:0]  regWrData,
  input  logic           sampleValid,
  input  logic           sampleFault,
  input  logic [CHW-1:0] sampleChan,
  input  logic           cellTick,
  input  logic           tempTick,
  input  logic [NCH-1:0] atAmount,
  output logic [SW-1:0]  setupQ,
  output fq_strobe_t     strobe,
  output logic           totalError,
  output logic           wireTick
);
  localparam int DIV_W = FEXP;

  logic [NCH-1:0]    selVec;
  logic [NCH-1:0]    enMask;
  logic [TOT_W-1:0]  totCode;
  logic [SCAN_W-1:0] scanCode;
  logic              accept;
  logic              hitAtAmount;
  logic              setErr;
  logic              fastScan;
  logic [DIV_W-1:0]  divLimit;
  logic [DIV_W-1:0]  divCnt;
  logic              wireNext;

  assign enMask   = setupQ[EN_LSB +: NCH];
  assign totCode  = setupQ[TOT_LSB +: TOT_W];
  assign scanCode = setupQ[SCAN_W-1:0];

  // one-hot channel select; out-of-range indices select nothing
  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign selVec[i] = (sampleChan == CHW'(i));
  end

  assign accept      = sampleValid && !totalError && !regWrEn && (|(selVec & enMask));
  assign hitAtAmount = |(selVec & atAmount);
  assign setErr      = accept && sampleFault && hitAtAmount;

  always_comb begin
    strobe.clrAll  = regWrEn;
    strobe.amount  = CNT_W'(1) << totCode;
    strobe.incMask = (accept && sampleFault && !hitAtAmount) ? (selVec & enMask) : '0;
    strobe.rstMask = (accept && !sampleFault) ? (selVec & enMask) : '0;
  end

  // wire-scan divider
  always_comb begin
    fastScan = (int'(scanCode) <= FEXP);
    divLimit = '1;
    if (fastScan) divLimit = DIV_W'((1 << (FEXP - int'(scanCode))) - 1);
    if (setupQ[WSEL_BIT])  wireNext = tempTick;
    else if (!fastScan)    wireNext = cellTick;
    else                   wireNext = cellTick && (divCnt == divLimit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setupQ     <= SETUP_RST;
      totalError <= 1'b0;
      divCnt     <= '0;
      wireTick   <= 1'b0;
    end else begin
      wireTick <= wireNext;
      if (regWrEn) begin
        setupQ     <= regWrData;
        totalError <= 1'b0;
        divCnt     <= '0;
      end else begin
        if (setErr) totalError <= 1'b1;
        if (!setupQ[WSEL_BIT] && fastScan && cellTick)
          divCnt <= (divCnt == divLimit) ? '0 : divCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fq_datapath.sv
module fq_datapath
  import fq_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int CW  = CNT_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  fq_strobe_t     strobe,
  output logic [NCH-1:0] atAmount,
  output logic [NCH-1:0] faultConfirmed
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] runCnt;
    logic [CW-1:0] runNext;

    assign runNext     = runCnt + 1'b1;
    assign atAmount[i] = (runCnt == strobe.amount);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runCnt            <= '0;
        faultConfirmed[i] <= 1'b0;
      end else if (strobe.clrAll) begin
        runCnt            <= '0;
        faultConfirmed[i] <= 1'b0;
      end else if (strobe.rstMask[i]) begin
        runCnt <= '0;
      end else if (strobe.incMask[i]) begin
        runCnt <= runNext;
        if (runNext == strobe.amount) faultConfirmed[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fault_qualifier.sv
module fault_qualifier
  import fq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [SETUP_W-1:0] regWrData,
  output logic [SETUP_W-1:0] regRdData,
  input  logic               sampleValid,
  input  logic               sampleFault,
  input  logic [CH_W-1:0]    sampleChan,
  input  logic               cellTick,
  input  logic               tempTick,
  output logic               wireTick,
  output logic [NUM_CH-1:0]  faultConfirmed,
  output logic               totalError
);
  fq_strobe_t        strobe;
  logic [NUM_CH-1:0] atAmount;

  fq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .sampleValid(sampleValid), .sampleFault(sampleFault), .sampleChan(sampleChan),
    .cellTick(cellTick), .tempTick(tempTick), .atAmount(atAmount),
    .setupQ(regRdData), .strobe(strobe), .totalError(totalError), .wireTick(wireTick)
  );

  fq_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .atAmount(atAmount), .faultConfirmed(faultConfirmed)
  );
endmodule

// File: rtl/fault_qualifier_chk.sv
module fault_qualifier_chk
  import fq_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [SETUP_W-1:0] regWrData,
  input logic [SETUP_W-1:0] regRdData,
  input logic               sampleValid,
  input logic               sampleFault,
  input logic [CH_W-1:0]    sampleChan,
  input logic               cellTick,
  input logic               tempTick,
  input logic               wireTick,
  input logic [NUM_CH-1:0]  faultConfirmed,
  input logic               totalError
);
  assert_readback_R2: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regRdData == $past(regWrData));

  assert_confirm_needs_sample_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|(faultConfirmed & ~$past(faultConfirmed))) |-> $past(sampleValid && sampleFault && !regWrEn));

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (faultConfirmed & ~regRdData[EN_LSB +: NUM_CH]) == '0);

  assert_error_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (totalError && !regWrEn) |=> totalError);

  assert_error_freeze_R6: assert property (@(posedge clk) disable iff (!rstN)
    (totalError && !regWrEn) |=> $stable(faultConfirmed));

  assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (faultConfirmed == '0) && !totalError);

  assert_wire_temp_R8: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[WSEL_BIT] |=> wireTick == $past(tempTick));

  assert_wire_cell_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!regRdData[WSEL_BIT] && int'(regRdData[SCAN_W-1:0]) > FIXED_EXP) |=> wireTick == $past(cellTick));

  assert_wire_needs_cell_R10: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[WSEL_BIT] |=> (!wireTick || $past(cellTick)));
endmodule

bind fault_qualifier fault_qualifier_chk u_chk (.*);

// File: tb/test_fault_qualifier.sv
module test_fault_qualifier;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [13:0] regWrData = '0;
  logic [13:0] regRdData;
  logic        sampleValid = 1'b0;
  logic        sampleFault = 1'b0;
  logic [2:0]  sampleChan = '0;
  logic        cellTick = 1'b0;
  logic        tempTick = 1'b0;
  logic        wireTick;
  logic [4:0]  faultConfirmed;
  logic        totalError;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state
  logic [13:0] mSetup;
  int          mCnt [5];
  logic [4:0]  mConf;
  logic        mErr;
  int          mDiv;
  logic        mWire;

  always #10 clk = ~clk;

  fault_qualifier i_fault_qualifier (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .sampleValid(sampleValid), .sampleFault(sampleFault), .sampleChan(sampleChan),
    .cellTick(cellTick), .tempTick(tempTick), .wireTick(wireTick),
    .faultConfirmed(faultConfirmed), .totalError(totalError)
  );

  function automatic int amountOf(logic [13:0] s);
    return 1 << int'(s[7:5]);
  endfunction

  task automatic modelReset();
    mSetup = 14'h0170; mConf = '0; mErr = 1'b0; mDiv = 0; mWire = 1'b0;
    for (int i = 0; i < 5; i++) mCnt[i] = 0;
  endtask

  task automatic modelStep(input logic wr, input logic [13:0] wd, input logic sv, input logic sf,
                           input logic [2:0] sc, input logic ct, input logic tt);
    int code = int'(mSetup[3:0]);
    if (mSetup[4]) mWire = tt;
    else if (code > 5) mWire = ct;
    else begin
      int lim = 1 << (5 - code);
      mWire = 1'b0;
      if (ct) begin
        if (mDiv == lim - 1) begin mWire = 1'b1; mDiv = 0; end
        else mDiv = mDiv + 1;
      end
    end
    if (wr) begin
      mSetup = wd; mConf = '0; mErr = 1'b0; mDiv = 0;
      for (int i = 0; i < 5; i++) mCnt[i] = 0;
    end else if (sv && !mErr && sc < 5 && mSetup[8 + int'(sc)]) begin
      if (!sf) mCnt[sc] = 0;
      else if (mCnt[sc] == amountOf(mSetup)) mErr = 1'b1;
      else begin
        mCnt[sc] = mCnt[sc] + 1;
        if (mCnt[sc] == amountOf(mSetup)) mConf[sc] = 1'b1;
      end
    end
  endtask

  task automatic checkOut(input string tag);
    checks += 4;
    if (regRdData !== mSetup) begin
      fails++; $display("FAIL %s (readback R2) act=%h exp=%h", tag, regRdData, mSetup);
    end
    if (faultConfirmed !== mConf) begin
      fails++; $display("FAIL %s (confirm R3) act=%b exp=%b", tag, faultConfirmed, mConf);
    end
    if (totalError !== mErr) begin
      fails++; $display("FAIL %s (error R6) act=%b exp=%b", tag, totalError, mErr);
    end
    if (wireTick !== mWire) begin
      fails++; $display("FAIL %s (wire tick R8/R9/R10) act=%b exp=%b", tag, wireTick, mWire);
    end
  endtask

  // one cycle: drive at a falling edge, check at the next falling edge
  task automatic cyc(input logic wr, input logic [13:0] wd, input logic sv, input logic sf,
                     input logic [2:0] sc, input logic ct, input logic tt, input string tag);
    regWrEn = wr; regWrData = wd; sampleValid = sv; sampleFault = sf;
    sampleChan = sc; cellTick = ct; tempTick = tt;
    modelStep(wr, wd, sv, sf, sc, ct, tt);
    @(negedge clk);
    checkOut(tag);
  endtask

  task automatic samp(input logic sf, input logic [2:0] sc, input string tag);
    cyc(1'b0, 14'h0, 1'b1, sf, sc, 1'b0, 1'b0, tag);
  endtask

  task automatic wrSetup(input logic [13:0] wd, input string tag);
    cyc(1'b1, wd, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, tag);
  endtask

  task automatic ticks(input int n, input logic ct, input logic tt, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 14'h0, 1'b0, 1'b0, 3'd0, ct, tt, tag);
  endtask

  initial begin
    int cyclesLeft = 200000;
    while (!done && cyclesLeft > 0) begin @(posedge clk); cyclesLeft--; end
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1");

    // R8: wire tick follows temperature tick
    cyc(1'b0, 14'h0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b1, "R8");
    cyc(1'b0, 14'h0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, "R8");
    ticks(3, 1'b0, 1'b1, "R8");

    // R3/R4: amount 8 on channel 0
    for (int i = 0; i < 7; i++) samp(1'b1, 3'd0, "R3");
    samp(1'b0, 3'd0, "R4");
    for (int i = 0; i < 7; i++) samp(1'b1, 3'd0, "R4");
    samp(1'b1, 3'd0, "R3");
    ticks(2, 1'b0, 1'b0, "R3");

    // R6: overflow then lock
    samp(1'b1, 3'd0, "R6");
    samp(1'b0, 3'd0, "R6");
    samp(1'b1, 3'd0, "R6");

    // R7: write clears, and a colliding sample is lost
    wrSetup(14'h1F03, "R7");
    cyc(1'b1, 14'h1F03, 1'b1, 1'b1, 3'd1, 1'b0, 1'b0, "R7");
    samp(1'b1, 3'd2, "R3");
    samp(1'b1, 3'd2, "R6");
    wrSetup(14'h1F03, "R7");

    // R11: out-of-range channel indices
    samp(1'b1, 3'd5, "R11");
    samp(1'b1, 3'd6, "R11");
    samp(1'b1, 3'd7, "R11");

    // R5: only channels 0 and 2 enabled, amount 2
    wrSetup(14'h0523, "R5");
    for (int i = 0; i < 4; i++) begin
      samp(1'b1, 3'd1, "R5"); samp(1'b1, 3'd3, "R5"); samp(1'b1, 3'd4, "R5");
    end
    samp(1'b1, 3'd2, "R5"); samp(1'b1, 3'd2, "R5");

    // R10: scan code 3 -> every 4th cell tick; scan code 0 -> every 32nd
    for (int i = 0; i < 10; i++) begin
      cyc(1'b0, 14'h0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b1, "R10");
      cyc(1'b0, 14'h0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, "R10");
    end
    wrSetup(14'h0100, "R10");
    ticks(70, 1'b1, 1'b0, "R10");
    wrSetup(14'h0105, "R10");
    ticks(4, 1'b1, 1'b0, "R10");

    // R9: scan code 7 follows the cell tick
    wrSetup(14'h0107, "R9");
    ticks(3, 1'b1, 1'b0, "R9");
    ticks(2, 1'b0, 1'b1, "R9");
    cyc(1'b0, 14'h0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, "R9");

    // random mix, small totalizer codes so confirmations and overflows occur
    for (int i = 0; i < 4000; i++) begin
      logic        wr = ($urandom % 64) == 0;
      logic [13:0] wd = 14'($urandom) & 14'h3F7F;
      logic        sv = ($urandom % 2) == 0;
      logic        sf = ($urandom % 5) != 0;
      logic [2:0]  sc = 3'($urandom);
      logic        ct = ($urandom % 3) == 0;
      logic        tt = ($urandom % 4) == 0;
      cyc(wr, wd, sv, sf, sc, ct, tt, "RND");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule